// File: doc/BRIEF.md
# Dual-Mode Serial Character Transmitter

This block takes one parallel character at a time through a valid/ready handshake and sends it out on a serial line. It has two modes. In start/stop mode it frames the character with a low start bit and a high stop bit, and it can add a parity bit. In clocked mode it shifts eight data bits out and drives a serial clock of its own next to the data.

A four-bit field of an 8-bit mode input chooses the mode, the character length, whether parity is used and the parity sense. The block captures this field when it accepts a character and keeps it until that character has gone out. Bit timing comes from an external baud tick. A start/stop bit lasts 16 ticks. A clocked-mode bit lasts 2 ticks: the serial clock is low for the first tick and high for the second.

Top module: `ser_char_tx`

## Requirements
- R1: After reset, and at any time no character is in flight, the serial line is 1, the serial clock is 1, busy is 0, ready is 1 and done is 0.
- R2: With mode bit 7 at 0, the line carries a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts 16 baud ticks.
- R3: With mode bit 7 at 0 and mode bit 6 at 1, only data bits 0 to 6 are sent and bit 7 of the data byte never reaches the line. With bit 6 at 0, all eight bits are sent.
- R4: With mode bit 7 at 0 and mode bit 5 at 1, one parity bit is sent between the last data bit and the stop bit. With bit 5 at 0, no parity bit is sent.
- R5: Mode bit 4 sets the parity sense. With bit 4 at 0, the data bits sent plus the parity bit hold an even number of 1s. With bit 4 at 1, they hold an odd number of 1s.
- R6: With mode bit 7 at 1, exactly eight data bits are sent LSB first, with no start, stop or parity bit, whatever mode bits 6 to 4 hold.
- R7: In clocked mode the serial clock falls at the start of each bit, together with the data change, and rises after one tick. In start/stop mode, and whenever the block is idle, the serial clock stays 1.
- R8: A bit position advances only on clock edges where the baud tick is 1. With the tick held at 0, the line and the serial clock hold their values.
- R9: Ready is 1 exactly when the block is idle. A character is accepted on a clock edge where valid and ready are both 1. Valid raised while busy is ignored.
- R10: The mode field is captured when a character is accepted. Changing it during that character has no effect on the character.
- R11: Done is a one-cycle pulse in the cycle after the edge that ends the last bit. Busy falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txData | input | 8 | Character to send |
| txValid | input | 1 | Character offered |
| txReady | output | 1 | Block can accept a character |
| modeIn | input | 8 | Bit 7 mode (1 = clocked), bit 6 seven-bit length, bit 5 parity enable, bit 4 odd parity; bits 3 to 0 unused |
| baudTick | input | 1 | One-cycle bit-timing tick |
| txLine | output | 1 | Serial data line, idles high |
| sClk | output | 1 | Serial clock in clocked mode, idles high |
| busy | output | 1 | Character in flight |
| done | output | 1 | One-cycle pulse after a character ends |

## Verification
The vector table tries start/stop frames with 8-bit and 7-bit data, each with no parity, even parity and odd parity.

Some data bytes have bit 7 set. In 7-bit mode this shows whether bit 7 is wrongly sent or wrongly counted in the parity. One byte is all zero in its low seven bits, which shows whether the odd-parity inversion is applied.

Two clocked-mode vectors, one with the length and parity bits clear and one with them set, show whether those bits are ignored in clocked mode. Directed tests then hold the tick low mid-bit, change the mode field in mid-flight and offer a second byte while the block is busy.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  // Mode field captured at the start of each character
  typedef struct packed {
    logic syncMode;
    logic sevenBit;
    logic parEn;
    logic parOdd;
  } txMode_t;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic load;
    logic shift;
  } txStrobe_t;

endpackage

// File: rtl/ser_tx_dp.sv
module ser_tx_dp
  import ser_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int BCNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  txMode_t           modeNext,
  input  txStrobe_t         strb,
  input  logic              busy,
  output logic              syncMode,
  output logic [BCNT_W-1:0] frameLen,
  output logic              txLine
);

  logic [FRAME_W-1:0] frameQ, frameNxt;
  logic [BCNT_W-1:0]  lenQ, lenNxt;
  txMode_t            modeQ;
  logic               parity;
  int                 nBits;

  // Build the bit sequence, LSB first, with unused upper positions at 1
  always_comb begin
    frameNxt = '1;
    lenNxt   = '0;
    parity   = modeNext.parOdd;
    nBits    = DATA_W;
    if (modeNext.syncMode) begin
      frameNxt[DATA_W-1:0] = txData;
      lenNxt = BCNT_W'(DATA_W);
    end else begin
      nBits = modeNext.sevenBit ? DATA_W - 1 : DATA_W;
      frameNxt[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (i < nBits) begin
          frameNxt[i+1] = txData[i];
          parity = parity ^ txData[i];
        end
      end
      if (modeNext.parEn) frameNxt[nBits+1] = parity;
      lenNxt = BCNT_W'(nBits + 2 + (modeNext.parEn ? 1 : 0));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '1;
      lenQ   <= '0;
      modeQ  <= '0;
    end else if (strb.load) begin
      frameQ <= frameNxt;
      lenQ   <= lenNxt;
      modeQ  <= modeNext;
    end else if (strb.shift) begin
      frameQ <= {1'b1, frameQ[FRAME_W-1:1]};
    end
  end

  assign syncMode = modeQ.syncMode;
  assign frameLen = lenQ;
  assign txLine   = busy ? frameQ[0] : 1'b1;

endmodule

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int SYNC_TICKS = 2,
  parameter int BCNT_W     = 4,
  parameter int TMAX       = (OVERSAMPLE > SYNC_TICKS) ? OVERSAMPLE : SYNC_TICKS,
  parameter int TCNT_W     = (TMAX > 1) ? $clog2(TMAX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txValid,
  input  logic              baudTick,
  input  logic              syncMode,
  input  logic [BCNT_W-1:0] frameLen,
  output txStrobe_t         strb,
  output logic              txReady,
  output logic              busy,
  output logic              done,
  output logic              sClk
);

  localparam int SYNC_HALF = SYNC_TICKS / 2;

  logic [TCNT_W-1:0] tickCnt, tickLast;
  logic [BCNT_W-1:0] bitCnt;
  logic              busyQ, doneQ, bitEnd, lastBit;

  assign tickLast = syncMode ? TCNT_W'(SYNC_TICKS - 1) : TCNT_W'(OVERSAMPLE - 1);
  assign bitEnd   = busyQ && baudTick && (tickCnt == tickLast);
  assign lastBit  = (bitCnt == frameLen - 1'b1);

  always_comb begin
    strb.load  = txValid && !busyQ;
    strb.shift = bitEnd && !lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      doneQ <= bitEnd && lastBit;
      if (strb.load) begin
        busyQ   <= 1'b1;
        tickCnt <= '0;
        bitCnt  <= '0;
      end else if (busyQ && baudTick) begin
        if (tickCnt == tickLast) begin
          tickCnt <= '0;
          if (lastBit) busyQ <= 1'b0;
          else         bitCnt <= bitCnt + 1'b1;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  assign txReady = !busyQ;
  assign busy    = busyQ;
  assign done    = doneQ;
  assign sClk    = !(busyQ && syncMode && (tickCnt < TCNT_W'(SYNC_HALF)));

endmodule

// File: rtl/ser_char_tx.sv
module ser_char_tx
  import ser_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int SYNC_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  input  logic [7:0] modeIn,
  input  logic       baudTick,
  output logic       txLine,
  output logic       sClk,
  output logic       busy,
  output logic       done
);

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  txStrobe_t         strb;
  txMode_t           modeNext;
  logic              syncMode;
  logic [BCNT_W-1:0] frameLen;

  // Mode field positions: 7 clocked mode, 6 seven-bit, 5 parity enable, 4 odd
  assign modeNext = '{syncMode: modeIn[7], sevenBit: modeIn[6],
                      parEn: modeIn[5], parOdd: modeIn[4]};

  ser_tx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .SYNC_TICKS(SYNC_TICKS),
    .BCNT_W(BCNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .txValid(txValid), .baudTick(baudTick),
    .syncMode(syncMode), .frameLen(frameLen), .strb(strb),
    .txReady(txReady), .busy(busy), .done(done), .sClk(sClk)
  );

  ser_tx_dp #(
    .DATA_W(DATA_W),
    .FRAME_W(FRAME_W),
    .BCNT_W(BCNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .txData(txData), .modeNext(modeNext),
    .strb(strb), .busy(busy), .syncMode(syncMode), .frameLen(frameLen),
    .txLine(txLine)
  );

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic baudTick,
  input logic txLine,
  input logic sClk,
  input logic busy,
  input logic done
);

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (txLine && sClk));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> busy);

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !txReady);

  p_sclk_fall_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sClk) |-> busy);

  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy && !$past(baudTick)) |-> ($stable(txLine) && $stable(sClk)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

endmodule

bind ser_char_tx ser_tx_chk chk_i (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .baudTick(baudTick), .txLine(txLine), .sClk(sClk), .busy(busy), .done(done)
);

// File: tb/ser_char_tx_tb_top.sv
module ser_char_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic [7:0] modeIn = 8'h00;
  logic       baudTick = 1'b1;
  logic       txReady, txLine, sClk, busy, done;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;  // 250 MHz

  ser_char_tx dut_i (
    .clk(clk), .rstN(rstN), .txData(txData), .txValid(txValid),
    .txReady(txReady), .modeIn(modeIn), .baudTick(baudTick),
    .txLine(txLine), .sClk(sClk), .busy(busy), .done(done)
  );

  // {mode, data}
  localparam logic [15:0] VECS [8] = '{
    16'h00A5, 16'h40D3, 16'h2037, 16'h3037,
    16'h60F1, 16'h7080, 16'h806C, 16'hF09B
  };

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Expected bit sequence from the requirements
  task automatic expFrame(input logic [7:0] d, input logic [7:0] m,
                          output logic [10:0] bits, output int len,
                          output int nData, output bit hasPar);
    bits = '1; len = 0; nData = 8; hasPar = 0;
    if (m[7]) begin
      bits[7:0] = d; len = 8;
    end else begin
      logic p;
      nData = m[6] ? 7 : 8;
      p = m[4];
      bits[0] = 1'b0;
      for (int i = 0; i < nData; i++) begin
        bits[i+1] = d[i];
        p ^= d[i];
      end
      hasPar = m[5];
      if (hasPar) bits[nData+1] = p;
      len = nData + 2 + (hasPar ? 1 : 0);
    end
  endtask

  // Accept a character; returns at the negedge of the first cycle of bit 0
  task automatic startChar(input logic [7:0] d, input logic [7:0] m);
    @(negedge clk);
    chk("R9", txReady, 1'b1, "ready before offer");
    txData = d; modeIn = m; txValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
    chk("R9", busy, 1'b1, "busy after accept");
  endtask

  // Walk every bit of the character and then the end of frame
  task automatic walkFrame(input logic [7:0] d, input logic [7:0] m);
    logic [10:0] bits; int len, nData; bit hasPar;
    int per;
    string tag;
    expFrame(d, m, bits, len, nData, hasPar);
    per = m[7] ? 2 : 16;
    for (int b = 0; b < len; b++) begin
      if (m[7]) tag = "R6";
      else if (b == 0 || b == len - 1) tag = "R2";
      else if (hasPar && b == len - 2) tag = "R4/R5";
      else if (nData == 7) tag = "R3";
      else tag = "R2";
      if (m[7]) chk("R7", sClk, 1'b0, "sclk low first tick");
      for (int t = 0; t < per / 2; t++) @(negedge clk);
      chk(tag, txLine, bits[b], $sformatf("bit %0d", b));
      chk("R7", sClk, 1'b1, "sclk high second half");
      for (int t = per / 2; t < per; t++) @(negedge clk);
    end
    chk("R11", done, 1'b1, "done after last bit");
    chk("R11", busy, 1'b0, "busy low after last bit");
    chk("R1", txLine, 1'b1, "idle line");
    @(negedge clk);
    chk("R11", done, 1'b0, "done one cycle");
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    #1;
    chk("R1", txLine, 1'b1, "line in reset");
    chk("R1", sClk, 1'b1, "sclk in reset");
    chk("R1", busy, 1'b0, "busy in reset");
    chk("R1", done, 1'b0, "done in reset");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", txReady, 1'b1, "ready after reset");
    chk("R1", txLine, 1'b1, "line after reset");

    // Vector table
    for (int v = 0; v < 8; v++) begin
      startChar(VECS[v][7:0], VECS[v][15:8]);
      walkFrame(VECS[v][7:0], VECS[v][15:8]);
    end

    // R8: tick held low freezes the start bit
    baudTick = 1'b0;
    startChar(8'h5A, 8'h00);
    for (int k = 0; k < 40; k++) @(negedge clk);
    chk("R8", txLine, 1'b0, "start bit held without ticks");
    chk("R8", busy, 1'b1, "busy held without ticks");
    baudTick = 1'b1;
    walkFrame(8'h5A, 8'h00);

    // R8: clocked mode frozen with the serial clock low
    baudTick = 1'b0;
    startChar(8'hC3, 8'h80);
    for (int k = 0; k < 20; k++) @(negedge clk);
    chk("R8", sClk, 1'b0, "sclk held without ticks");
    baudTick = 1'b1;
    walkFrame(8'hC3, 8'h80);

    // R10: mode change mid-character is not taken; R9: valid while busy ignored
    startChar(8'h96, 8'h30);
    fork
      walkFrame(8'h96, 8'h30);
      begin
        modeIn = 8'hC0;
        repeat (3) @(negedge clk);
        txData = 8'h00; txValid = 1'b1;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk("R9", txReady, 1'b0, "ready while busy");
        end
        txValid = 1'b0;
      end
    join
    chk("R10", busy, 1'b0, "frame completed with captured mode");
    for (int k = 0; k < 20; k++) @(negedge clk);
    chk("R9", txLine, 1'b1, "ignored byte never sent");
    chk("R9", busy, 1'b0, "no second character");
    chk("R7", sClk, 1'b1, "sclk idle high");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule